// File: doc/BRIEF.md
# Decoder Command, Status and Soft-Reset Controller

This block is the CPU-facing control front end of a bitstream decoding engine. Through a small word-addressed register port the CPU issues commands, programs an interrupt-enable mask, watches a status register of sticky event flags and presets or reads four activity counters. The decoding datapath reports events on single-cycle pulse inputs. The DMA engine is seen only through a request pass-through and a busy input.

A soft-reset command does not act at once. The controller first stops passing new DMA requests to the engine. It then waits until no transfer is outstanding, which covers a transfer already running and one whose request left in the previous cycle. It then raises a ready-to-reset strobe and an interrupt for one clock. On that edge it returns the command, control and counter registers to zero and the status register to "command done". Status event flags clear when the CPU writes one to them. The command-done flag is the exception: writes to it have no effect, and only a newly accepted command clears it.

Top module: `cmd_status_ctrl`

## Requirements
- R1: Status bits 1 (input transfer done), 2 (decode error) and 3 (header found) are cleared by writing 1 to that bit at the status address. Writing 0 leaves the bit unchanged.
- R2: Status bit 0 (command done) is cleared only when a command write is accepted. Writing 1 to bit 0 of the status address has no effect.
- R3: cmd_done_i, err_evt_i and hdr_evt_i set status bits 0, 2 and 3 independently of each other. Any combination of them may be set at once.
- R4: After a soft-reset command is accepted, dma_req_o is held low until the sequence ends. The reset step waits until dma_busy_i is low and dma_req_o was low in the previous cycle.
- R5: rdy_rst_o is high for exactly one clock per soft reset, and irq_o is high in that same clock.
- R6: On the clock ending a soft reset, the command, control and all four counter registers become 0 and status becomes 0x1.
- R7: After rst_ni is released, every register holds the same values as in R6, and irq_o is 0.
- R8: Zeroing the input counter by soft reset, or by a CPU write, never sets status bit 1.
- R9: When an event pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R10: When a command write and cmd_done_i fall in the same cycle, status bit 0 ends up clear.
- R11: irq_o is high whenever the AND of status and control bits [3:0] is nonzero.
- R12: The input counter (address 4) counts down on in_word_i and holds at 0. A decrement from 1 to 0 sets status bit 1. The bit, header and run-level counters (addresses 3, 5, 6) each count up by one per pulse of bit_evt_i, hdr_evt_i and rl_evt_i.
- R13: While a soft reset is pending, a write to the command address changes no register and produces no start pulse.
- R14: Address map: 0 command (bits [3:0]), 1 control, 2 status, 3 to 6 counters. Command code 0xF requests soft reset. Any other accepted code pulses cmd_start_o for one clock in the next cycle, with cmd_code_o holding the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| cmd_start_o | output | 1 | One-clock start pulse to the datapath |
| cmd_code_o | output | 4 | Current command code |
| cmd_done_i | input | 1 | Datapath finished a command |
| err_evt_i | input | 1 | Datapath decode error pulse |
| hdr_evt_i | input | 1 | Datapath header found pulse |
| rl_evt_i | input | 1 | Run-level pair produced pulse |
| bit_evt_i | input | 1 | Bitstream advance pulse |
| in_word_i | input | 1 | Input word consumed pulse |
| dp_dma_req_i | input | 1 | Datapath asks for a DMA transfer |
| dma_req_o | output | 1 | Request forwarded to the DMA engine |
| dma_busy_i | input | 1 | DMA engine has a transfer in progress |
| rdy_rst_o | output | 1 | Ready-to-reset strobe |
| irq_o | output | 1 | Interrupt to the CPU |

## Verification
Two pairs of events can land on the status register in the same cycle. An event pulse can coincide with the CPU's write-one-to-clear of the same bit, and a new command write can coincide with the previous command's done pulse. The bench drives both inputs on one falling edge, so they are sampled at the same rising edge. It then reads the status register and expects the error flag to stay set and the done flag to end clear. A second kind of overlap is a DMA request leaving in the very cycle the reset command is written. There the bench expects rdy_rst_o one clock later than in the idle case.

// File: rtl/cmd_status_pkg.sv
package cmd_status_pkg;
  localparam int unsigned DW    = 32;
  localparam int unsigned AW    = 3;
  localparam int unsigned CMD_W = 4;
  localparam int unsigned SW    = 4;
  localparam int unsigned NCNT  = 4;

  localparam logic [AW-1:0] A_CMD  = 3'd0;
  localparam logic [AW-1:0] A_CTL  = 3'd1;
  localparam logic [AW-1:0] A_STAT = 3'd2;
  localparam logic [AW-1:0] A_BIT  = 3'd3;
  localparam logic [AW-1:0] A_RL   = 3'd6;

  localparam logic [CMD_W-1:0] CMD_SOFT_RST = 4'hF;

  // counter slots: 0 bit, 1 input, 2 header, 3 run-level
  localparam int unsigned CNT_INP = 1;

  // status bits
  localparam int unsigned ST_DONE = 0;
  localparam int unsigned ST_INP  = 1;
  localparam int unsigned ST_ERR  = 2;
  localparam int unsigned ST_HDR  = 3;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_DRAIN = 2'd1,
    SQ_CLEAR = 2'd2,
    SQ_DONE  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/csr_seq.sv
module csr_seq
  import cmd_status_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rst_cmd_i,
  input  logic dma_busy_i,
  input  logic dma_req_i,
  output logic idle_o,
  output logic clr_o
);
  seq_state_e state_q, state_d;
  logic       issued_q;

  // a request sent last cycle may not show as busy yet
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) issued_q <= 1'b0;
    else         issued_q <= dma_req_i;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE:  if (rst_cmd_i) state_d = SQ_DRAIN;
      SQ_DRAIN: if (!dma_busy_i && !issued_q) state_d = SQ_CLEAR;
      SQ_CLEAR: state_d = SQ_DONE;
      SQ_DONE:  state_d = SQ_IDLE;
      default:  state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SQ_IDLE;
    else         state_q <= state_d;
  end

  assign idle_o = (state_q == SQ_IDLE);
  assign clr_o  = (state_q == SQ_CLEAR);
endmodule

// File: rtl/csr_status.sv
module csr_status
  import cmd_status_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [SW-1:0] set_i,
  input  logic          w1c_we_i,
  input  logic [SW-1:0] w1c_data_i,
  input  logic          cmd_wr_i,
  output logic [SW-1:0] status_o
);
  logic [SW-1:0] st_q;

  for (genvar b = 0; b < SW; b++) begin : g_bit
    if (b == ST_DONE) begin : g_done
      // only a new command clears it; w1c data ignored
      logic unused_w1c0;
      assign unused_w1c0 = w1c_data_i[b];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       st_q[b] <= 1'b1;
        else if (clr_i)    st_q[b] <= 1'b1;
        else if (cmd_wr_i) st_q[b] <= 1'b0;
        else if (set_i[b]) st_q[b] <= 1'b1;
      end
    end else begin : g_evt
      // set beats clear so no event is lost
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                         st_q[b] <= 1'b0;
        else if (clr_i)                      st_q[b] <= 1'b0;
        else if (set_i[b])                   st_q[b] <= 1'b1;
        else if (w1c_we_i && w1c_data_i[b])  st_q[b] <= 1'b0;
      end
    end
  end

  assign status_o = st_q;
endmodule

// File: rtl/csr_counter.sv
module csr_counter #(
  parameter int unsigned W    = 16,
  parameter bit          DOWN = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         step_i,
  output logic [W-1:0] cnt_o,
  output logic         hit_o
);
  logic [W-1:0] cnt_q, cnt_nxt;

  if (DOWN) begin : g_down
    assign cnt_nxt = (cnt_q == '0) ? cnt_q : cnt_q - W'(1);
    // only a real decrement to zero counts as an event
    assign hit_o   = step_i && !we_i && !clr_i && (cnt_q == W'(1));
  end else begin : g_up
    assign cnt_nxt = cnt_q + W'(1);
    assign hit_o   = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (we_i)   cnt_q <= wdata_i;
    else if (step_i) cnt_q <= cnt_nxt;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/cmd_status_ctrl.sv
module cmd_status_ctrl
  import cmd_status_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned CTL_W = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          cmd_start_o,
  output logic [CMD_W-1:0] cmd_code_o,
  input  logic          cmd_done_i,
  input  logic          err_evt_i,
  input  logic          hdr_evt_i,
  input  logic          rl_evt_i,
  input  logic          bit_evt_i,
  input  logic          in_word_i,
  input  logic          dp_dma_req_i,
  output logic          dma_req_o,
  input  logic          dma_busy_i,
  output logic          rdy_rst_o,
  output logic          irq_o
);
  logic             idle, clr;
  logic             wr_cmd, cmd_acc, rst_cmd;
  logic [CMD_W-1:0] cmd_q;
  logic             cmd_start_q;
  logic [CTL_W-1:0] ctl_q;
  logic [SW-1:0]    status_q, st_set;
  logic [NCNT-1:0]  cnt_step, cnt_we, cnt_hit;
  logic [CNT_W-1:0] cnt_val [NCNT];
  logic [1:0]       rd_idx;

  assign wr_cmd  = reg_we_i && (reg_addr_i == A_CMD);
  assign cmd_acc = wr_cmd && idle;
  assign rst_cmd = cmd_acc && (reg_wdata_i[CMD_W-1:0] == CMD_SOFT_RST);

  assign dma_req_o = dp_dma_req_i && idle;

  csr_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_cmd_i  (rst_cmd),
    .dma_busy_i (dma_busy_i),
    .dma_req_i  (dma_req_o),
    .idle_o     (idle),
    .clr_o      (clr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q       <= '0;
      cmd_start_q <= 1'b0;
      ctl_q       <= '0;
    end else if (clr) begin
      cmd_q       <= '0;
      cmd_start_q <= 1'b0;
      ctl_q       <= '0;
    end else begin
      cmd_start_q <= cmd_acc && !rst_cmd;
      if (cmd_acc) cmd_q <= reg_wdata_i[CMD_W-1:0];
      if (reg_we_i && (reg_addr_i == A_CTL)) ctl_q <= reg_wdata_i[CTL_W-1:0];
    end
  end

  assign cmd_start_o = cmd_start_q;
  assign cmd_code_o  = cmd_q;

  assign cnt_step = {rl_evt_i, hdr_evt_i, in_word_i, bit_evt_i};

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    assign cnt_we[i] = reg_we_i && (reg_addr_i == A_BIT + AW'(i));
    csr_counter #(
      .W    (CNT_W),
      .DOWN (i == CNT_INP)
    ) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clr),
      .we_i    (cnt_we[i]),
      .wdata_i (reg_wdata_i[CNT_W-1:0]),
      .step_i  (cnt_step[i]),
      .cnt_o   (cnt_val[i]),
      .hit_o   (cnt_hit[i])
    );
  end

  assign st_set[ST_DONE] = cmd_done_i;
  assign st_set[ST_INP]  = |cnt_hit;
  assign st_set[ST_ERR]  = err_evt_i;
  assign st_set[ST_HDR]  = hdr_evt_i;

  csr_status u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .set_i      (st_set),
    .w1c_we_i   (reg_we_i && (reg_addr_i == A_STAT)),
    .w1c_data_i (reg_wdata_i[SW-1:0]),
    .cmd_wr_i   (cmd_acc),
    .status_o   (status_q)
  );

  assign rdy_rst_o = clr;
  assign irq_o     = (|(status_q & ctl_q[SW-1:0])) || clr;

  assign rd_idx = 2'(reg_addr_i - A_BIT);

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CMD:  reg_rdata_o[CMD_W-1:0] = cmd_q;
      A_CTL:  reg_rdata_o[CTL_W-1:0] = ctl_q;
      A_STAT: reg_rdata_o[SW-1:0]    = status_q;
      default:
        if (reg_addr_i >= A_BIT && reg_addr_i <= A_RL)
          reg_rdata_o[CNT_W-1:0] = cnt_val[rd_idx];
    endcase
  end

  if (CNT_W < DW) begin : g_wd
    logic unused_wdata;
    assign unused_wdata = ^reg_wdata_i[DW-1:CNT_W];
  end
endmodule

// File: rtl/cmd_status_chk.sv
module cmd_status_chk
  import cmd_status_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_we_i,
  input logic [AW-1:0] reg_addr_i,
  input logic [DW-1:0] reg_wdata_i,
  input logic [SW-1:0] status_q,
  input logic          idle,
  input logic          err_evt_i,
  input logic          dma_req_o,
  input logic          dma_busy_i,
  input logic          rdy_rst_o,
  input logic          irq_o
);
  AST_DONE_CMD_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_q[ST_DONE]) |-> $past(reg_we_i && reg_addr_i == A_CMD && idle)); // R2

  for (genvar b = 1; b < SW; b++) begin : g_w1c
    AST_W1C_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(status_q[b]) |-> $past(rdy_rst_o || (reg_we_i && reg_addr_i == A_STAT && reg_wdata_i[b]))); // R1
  end

  AST_DRAIN_SAFE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_rst_o |-> (!dma_busy_i && !$past(dma_req_o))); // R4

  AST_RDY_ONE_CYC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_rst_o |=> !rdy_rst_o); // R5

  AST_POST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rdy_rst_o) |-> (status_q == SW'(1) && !irq_o)); // R6

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(err_evt_i && !rdy_rst_o) |-> status_q[ST_ERR]); // R9
endmodule

bind cmd_status_ctrl cmd_status_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .status_q    (status_q),
  .idle        (idle),
  .err_evt_i   (err_evt_i),
  .dma_req_o   (dma_req_o),
  .dma_busy_i  (dma_busy_i),
  .rdy_rst_o   (rdy_rst_o),
  .irq_o       (irq_o)
);

// File: tb/sim_cmd_status_ctrl.sv
`timescale 1ns/1ps
module sim_cmd_status_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        cmd_start_o;
  logic [3:0]  cmd_code_o;
  logic        cmd_done_i = 0, err_evt_i = 0, hdr_evt_i = 0, rl_evt_i = 0;
  logic        bit_evt_i = 0, in_word_i = 0, dp_dma_req_i = 0, dma_busy_i = 0;
  logic        dma_req_o, rdy_rst_o, irq_o;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  localparam logic [2:0] A_CMD = 0, A_CTL = 1, A_STAT = 2, A_BIT = 3, A_INP = 4, A_MBH = 5, A_RL = 6;

  always #10 clk = ~clk;

  cmd_status_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .cmd_start_o(cmd_start_o),
    .cmd_code_o(cmd_code_o), .cmd_done_i(cmd_done_i), .err_evt_i(err_evt_i),
    .hdr_evt_i(hdr_evt_i), .rl_evt_i(rl_evt_i), .bit_evt_i(bit_evt_i),
    .in_word_i(in_word_i), .dp_dma_req_i(dp_dma_req_i), .dma_req_o(dma_req_o),
    .dma_busy_i(dma_busy_i), .rdy_rst_o(rdy_rst_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
    reg_addr_i = a;
    #1;
    chk(req, reg_rdata_o, exp);
  endtask

  task automatic t_reset;
    rd_chk("R7 status", A_STAT, 32'h1);
    rd_chk("R7 ctl", A_CTL, 0);
    rd_chk("R7 cmd", A_CMD, 0);
    for (int i = 3; i <= 6; i++) rd_chk("R7 counter", 3'(i), 0);
    chk("R7 irq", irq_o, 0);
    chk("R7 rdy", rdy_rst_o, 0);
  endtask

  task automatic t_cmd;
    wr(A_CMD, 32'h2);
    chk("R14 start", cmd_start_o, 1);
    chk("R14 code", cmd_code_o, 2);
    rd_chk("R2 cleared by cmd", A_STAT, 0);
    @(negedge clk);
    chk("R14 start one clk", cmd_start_o, 0);
    wr(A_STAT, 32'h1);
    rd_chk("R2 w1 on bit0 ignored", A_STAT, 0);
    cmd_done_i = 1; @(negedge clk); cmd_done_i = 0;
    rd_chk("R3 done set", A_STAT, 1);
  endtask

  task automatic t_w1c;
    err_evt_i = 1; hdr_evt_i = 1; @(negedge clk); err_evt_i = 0; hdr_evt_i = 0;
    rd_chk("R3 two events", A_STAT, 32'hD);
    rd_chk("R12 header count", A_MBH, 1);
    wr(A_STAT, 32'h0);
    rd_chk("R1 write zero", A_STAT, 32'hD);
    wr(A_STAT, 32'h4);
    rd_chk("R1 clear err only", A_STAT, 32'h9);
    wr(A_STAT, 32'h8);
    rd_chk("R1 clear hdr", A_STAT, 32'h1);
  endtask

  task automatic t_collide;
    err_evt_i = 1; reg_we_i = 1; reg_addr_i = A_STAT; reg_wdata_i = 32'h4;
    @(negedge clk);
    err_evt_i = 0; reg_we_i = 0;
    rd_chk("R9 set beats clear", A_STAT, 32'h5);
    wr(A_STAT, 32'h4);
    cmd_done_i = 1; reg_we_i = 1; reg_addr_i = A_CMD; reg_wdata_i = 32'h3;
    @(negedge clk);
    cmd_done_i = 0; reg_we_i = 0;
    rd_chk("R10 cmd beats done", A_STAT, 0);
    cmd_done_i = 1; @(negedge clk); cmd_done_i = 0;
  endtask

  task automatic t_irq;
    wr(A_CTL, 32'h4);
    chk("R11 masked done", irq_o, 0);
    err_evt_i = 1; @(negedge clk); err_evt_i = 0;
    chk("R11 err enabled", irq_o, 1);
    hdr_evt_i = 1; @(negedge clk); hdr_evt_i = 0;
    wr(A_STAT, 32'h4);
    chk("R11 hdr masked", irq_o, 0);
    wr(A_STAT, 32'h8);
    wr(A_CTL, 32'h0);
  endtask

  task automatic t_inp;
    wr(A_INP, 32'h2);
    rd_chk("R8 write no event", A_STAT, 1);
    in_word_i = 1; @(negedge clk); in_word_i = 0;
    rd_chk("R12 dec", A_INP, 1);
    rd_chk("R12 no early event", A_STAT, 1);
    in_word_i = 1; @(negedge clk); in_word_i = 0;
    rd_chk("R12 zero", A_INP, 0);
    rd_chk("R12 zero event", A_STAT, 3);
    in_word_i = 1; @(negedge clk); in_word_i = 0;
    rd_chk("R12 saturate", A_INP, 0);
    wr(A_STAT, 32'h2);
    bit_evt_i = 1; rl_evt_i = 1; @(negedge clk); bit_evt_i = 0; rl_evt_i = 0;
    rd_chk("R12 bit count", A_BIT, 1);
    rd_chk("R12 rl count", A_RL, 1);
  endtask

  task automatic t_rst_busy;
    wr(A_INP, 32'h5);
    wr(A_CTL, 32'hF);
    err_evt_i = 1; @(negedge clk); err_evt_i = 0;
    dma_busy_i = 1; dp_dma_req_i = 1; #1;
    chk("R4 pass when idle", dma_req_o, 1);
    wr(A_CMD, 32'hF);
    chk("R4 req blocked", dma_req_o, 0);
    chk("R4 waits busy", rdy_rst_o, 0);
    wr(A_CMD, 32'h2);
    chk("R13 no start", cmd_start_o, 0);
    rd_chk("R13 cmd kept", A_CMD, 32'hF);
    repeat (3) @(negedge clk);
    chk("R4 still waits", rdy_rst_o, 0);
    chk("R4 still blocked", dma_req_o, 0);
    dma_busy_i = 0;
    @(negedge clk);
    chk("R5 rdy", rdy_rst_o, 1);
    chk("R5 irq", irq_o, 1);
    @(negedge clk);
    chk("R5 rdy one clk", rdy_rst_o, 0);
    rd_chk("R6 status", A_STAT, 1);
    rd_chk("R8 no inp event", A_STAT, 1);
    rd_chk("R6 cmd", A_CMD, 0);
    rd_chk("R6 ctl", A_CTL, 0);
    rd_chk("R6 inp", A_INP, 0);
    rd_chk("R6 bit", A_BIT, 0);
    chk("R6 irq", irq_o, 0);
    @(negedge clk); #1;
    chk("R4 req after reset", dma_req_o, 1);
    dp_dma_req_i = 0;
  endtask

  task automatic t_rst_inflight;
    dp_dma_req_i = 1;
    wr(A_CMD, 32'hF);
    dp_dma_req_i = 0;
    chk("R4 in-flight guard a", rdy_rst_o, 0);
    @(negedge clk);
    chk("R4 in-flight guard b", rdy_rst_o, 0);
    @(negedge clk);
    chk("R5 rdy after guard", rdy_rst_o, 1);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_cmd();
    t_w1c();
    t_collide();
    t_irq();
    t_inp();
    t_rst_busy();
    t_rst_inflight();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule